// File: doc/BRIEF.md
# Half-Word Loaded Transmit Queue

This block holds up to eight 32-bit words that a host writes in two 16-bit halves, then hands them in arrival order to a downstream serializer. The host pulses an active-low strobe to stage the low half from the 16-bit bus. It then pulses a second active-low strobe to add the high half and commit the whole word into the queue. Both strobes are asynchronous to the system clock. They are synchronised, and each one acts on its trailing (rising) edge.

Loading is allowed only while the transmit enable input is low. Raising the enable stops all loading and starts the drain. The head word is offered on a valid/ready handshake until the queue is empty. A full queue does not refuse a new word: the word overwrites the entry that was committed most recently. A transmitter-ready flag tells the host when the queue has emptied and the serializer has taken the last word, so that a new batch can be loaded.

Top module: `halfword_tx_queue`

## Requirements
- R1: After a synchronous reset (rst_n low at a clock edge) the queue is empty, `tx_valid` is 0 and `tx_ready_flag` is 1.
- R2: A trailing edge on `ld_lo_n` stages `host_data` as bits [15:0]. A later trailing edge on `ld_hi_n` commits a word with `host_data` in bits [31:16]. If `ld_lo_n` pulses again before the commit, the most recent low half is the one used.
- R3: A trailing edge on `ld_hi_n` with no staged low half since the last commit is ignored, and no word enters the queue.
- R4: Strobe edges that occur while `tx_en` is 1 are ignored. They neither stage nor commit data.
- R5: `tx_valid` is 1 only while `tx_en` is 1 and the queue holds at least one word. While `tx_en` is 0 nothing is offered.
- R6: Words leave in commit order, one per clock in which `tx_valid` and `ser_ready` are both 1. While `ser_ready` is 0, `tx_word` holds steady.
- R7: A commit while 8 words are queued replaces the most recently committed word. The queue depth stays 8.
- R8: `tx_ready_flag` drops to 0 on the clock after a commit. It returns to 1 only after a clock edge at which the queue is empty and `ser_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_data | input | 16 | Host half-word bus |
| ld_lo_n | input | 1 | Active-low strobe that stages the low half |
| ld_hi_n | input | 1 | Active-low strobe that adds the high half and commits the word |
| tx_en | input | 1 | Transmit enable; 1 drains the queue and locks out loading |
| ser_ready | input | 1 | Serializer can accept a word (idle) |
| tx_word | output | 32 | Head-of-queue word |
| tx_valid | output | 1 | `tx_word` is offered to the serializer |
| tx_ready_flag | output | 1 | Queue empty and serializer idle |

## Verification
The main path is tried with a short batch of three words, a batch of nine words that overfills the queue, and a stalled drain in which `ser_ready` is held low. The short batch shows that order is kept and that the halves go to the right bits. The overfilled batch shows that the last entry is overwritten rather than the write being dropped. Strobe patterns without a staged low half, with a repeated low half, or with loading while enabled show which edges the staging logic accepts. A serializer that stays busy after the last word shows that the ready flag waits for the serializer, not only for the queue to empty.

// File: rtl/txq_pkg.sv
// Shared types for the half-word transmit queue.
package txq_pkg;

    // Staging state of the half-word loader
    typedef enum logic {
        LD_EMPTY  = 1'b0,
        LD_STAGED = 1'b1
    } ld_state_t;

    // One-cycle strobe events after synchronisation
    typedef struct packed {
        logic hi_rise;
        logic lo_rise;
    } strobe_ev_t;

    // Circular pointer increment for any depth
    function automatic int unsigned wrap_next(int unsigned p, int unsigned depth);
        return (p == depth - 1) ? 0 : p + 1;
    endfunction

    // Circular pointer decrement for any depth
    function automatic int unsigned wrap_prev(int unsigned p, int unsigned depth);
        return (p == 0) ? depth - 1 : p - 1;
    endfunction

endpackage

// File: rtl/txq_strobe_sync.sv
// Synchronises N active-low strobes and emits a one-cycle pulse on each
// trailing (rising) edge. Assumes strobes stay low and high for at least
// two clock periods each. Idle level after reset is high (inactive).
module txq_strobe_sync #(
    parameter int NSTROBE = 2,
    parameter int STAGES  = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NSTROBE-1:0] strobe_n,
    output logic [NSTROBE-1:0] rise
);
    localparam int CHAIN = STAGES + 1;

    for (genvar g = 0; g < NSTROBE; g++) begin : g_strobe
        logic [CHAIN-1:0] chain_q;

        // Shift the strobe through the synchroniser and one history stage
        always_ff @(posedge clk) begin
            if (!rst_n) chain_q <= '1;
            else        chain_q <= {chain_q[CHAIN-2:0], strobe_n[g]};
        end

        // Trailing edge: synchronised level high, previous level low
        assign rise[g] = chain_q[CHAIN-2] & ~chain_q[CHAIN-1];
    end
endmodule

// File: rtl/txq_loader.sv
// Assembles a word from two half-word strobes. The low half is staged, and
// the high half commits the word. Edges are ignored while enable is high,
// and a high-half edge with nothing staged is ignored.
module txq_loader
    import txq_pkg::*;
#(
    parameter int HALF_W = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  strobe_ev_t          ev,
    input  logic                tx_en,
    input  logic [HALF_W-1:0]   host_data,
    output logic                commit,
    output logic [2*HALF_W-1:0] commit_word
);
    ld_state_t         state_q;
    logic [HALF_W-1:0] lo_q;
    logic              lo_ok;
    logic              hi_ok;

    // Qualify edges with the load lockout
    always_comb begin
        lo_ok = ev.lo_rise & ~tx_en;
        hi_ok = ev.hi_rise & ~tx_en & (state_q == LD_STAGED);
    end

    // Track whether a low half is staged
    always_ff @(posedge clk) begin
        if (!rst_n)     state_q <= LD_EMPTY;
        else if (hi_ok) state_q <= LD_EMPTY;
        else if (lo_ok) state_q <= LD_STAGED;
    end

    // Capture the most recent low half
    always_ff @(posedge clk) begin
        if (!rst_n)     lo_q <= '0;
        else if (lo_ok) lo_q <= host_data;
    end

    assign commit      = hi_ok;
    assign commit_word = {host_data, lo_q};
endmodule

// File: rtl/txq_store.sv
// Circular word store. A write when full replaces the newest entry, and the
// count does not change. Assumes write and read never occur in the same cycle.
module txq_store
    import txq_pkg::*;
#(
    parameter int WORD_W = 32,
    parameter int DEPTH  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              rd_en,
    output logic [WORD_W-1:0] head,
    output logic [CNT_W-1:0]  count,
    output logic              empty
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

    logic [WORD_W-1:0] mem [DEPTH];
    logic [PTR_W-1:0]  wr_ptr_q;
    logic [PTR_W-1:0]  rd_ptr_q;
    logic [CNT_W-1:0]  count_q;
    logic              full;
    logic [PTR_W-1:0]  wr_slot;

    assign full  = (count_q == FULL_CNT);
    assign empty = (count_q == '0);

    // Write to the next free slot, or over the newest entry when full
    always_comb begin
        if (full) wr_slot = PTR_W'(wrap_prev(int'(wr_ptr_q), DEPTH));
        else      wr_slot = wr_ptr_q;
    end

    // Storage array, no reset needed
    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_slot] <= wr_data;
    end

    // Write pointer advances only when a free slot was used
    always_ff @(posedge clk) begin
        if (!rst_n)              wr_ptr_q <= '0;
        else if (wr_en && !full) wr_ptr_q <= PTR_W'(wrap_next(int'(wr_ptr_q), DEPTH));
    end

    // Read pointer advances on each pop
    always_ff @(posedge clk) begin
        if (!rst_n)     rd_ptr_q <= '0;
        else if (rd_en) rd_ptr_q <= PTR_W'(wrap_next(int'(rd_ptr_q), DEPTH));
    end

    // Occupancy count
    always_ff @(posedge clk) begin
        if (!rst_n)                count_q <= '0;
        else if (wr_en && !full)   count_q <= count_q + 1'b1;
        else if (rd_en && !empty)  count_q <= count_q - 1'b1;
    end

    assign head  = mem[rd_ptr_q];
    assign count = count_q;
endmodule

// File: rtl/txq_drain.sv
// Offers the head word while enabled and generates the pop. Keeps the
// transmitter-ready flag: cleared by a commit, set once the queue is empty
// and the serializer reports ready.
module txq_drain (
    input  logic clk,
    input  logic rst_n,
    input  logic tx_en,
    input  logic empty,
    input  logic ser_ready,
    input  logic commit,
    output logic tx_valid,
    output logic pop,
    output logic tx_ready_flag
);
    logic rdy_q;

    assign tx_valid = tx_en & ~empty;
    assign pop      = tx_valid & ser_ready;

    // Ready flag: a commit clears it; an empty queue with an idle serializer sets it
    always_ff @(posedge clk) begin
        if (!rst_n)                  rdy_q <= 1'b1;
        else if (commit)             rdy_q <= 1'b0;
        else if (empty && ser_ready) rdy_q <= 1'b1;
    end

    assign tx_ready_flag = rdy_q;
endmodule

// File: rtl/halfword_tx_queue.sv
// Top of the half-word loaded transmit queue. Connects strobe
// synchronisation, word assembly, storage and drain control.
// Assumes host_data is stable around each strobe's trailing edge
// for at least three clock periods.
module halfword_tx_queue #(
    parameter int HALF_W = 16,
    parameter int DEPTH  = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [HALF_W-1:0]   host_data,
    input  logic                ld_lo_n,
    input  logic                ld_hi_n,
    input  logic                tx_en,
    input  logic                ser_ready,
    output logic [2*HALF_W-1:0] tx_word,
    output logic                tx_valid,
    output logic                tx_ready_flag
);
    import txq_pkg::*;

    localparam int WORD_W = 2 * HALF_W;
    localparam int CNT_W  = $clog2(DEPTH + 1);

    logic [1:0]        rise;
    strobe_ev_t        ev;
    logic              commit;
    logic [WORD_W-1:0] commit_word;
    logic              pop;
    logic              empty;
    logic [CNT_W-1:0]  fill_count;

    txq_strobe_sync #(.NSTROBE(2), .STAGES(2)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .strobe_n ({ld_hi_n, ld_lo_n}),
        .rise     (rise)
    );

    assign ev.lo_rise = rise[0];
    assign ev.hi_rise = rise[1];

    txq_loader #(.HALF_W(HALF_W)) u_loader (
        .clk         (clk),
        .rst_n       (rst_n),
        .ev          (ev),
        .tx_en       (tx_en),
        .host_data   (host_data),
        .commit      (commit),
        .commit_word (commit_word)
    );

    txq_store #(.WORD_W(WORD_W), .DEPTH(DEPTH)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (commit),
        .wr_data (commit_word),
        .rd_en   (pop),
        .head    (tx_word),
        .count   (fill_count),
        .empty   (empty)
    );

    txq_drain u_drain (
        .clk           (clk),
        .rst_n         (rst_n),
        .tx_en         (tx_en),
        .empty         (empty),
        .ser_ready     (ser_ready),
        .commit        (commit),
        .tx_valid      (tx_valid),
        .pop           (pop),
        .tx_ready_flag (tx_ready_flag)
    );
endmodule

// File: rtl/halfword_tx_queue_chk.sv
// Protocol checker for the half-word transmit queue, attached by bind.
module halfword_tx_queue_chk #(
    parameter int WORD_W = 32,
    parameter int DEPTH  = 8,
    parameter int CNT_W  = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              tx_en,
    input logic              ser_ready,
    input logic              tx_valid,
    input logic [WORD_W-1:0] tx_word,
    input logic              tx_ready_flag,
    input logic              commit,
    input logic [CNT_W-1:0]  fill_count
);
    assert_valid_needs_en_R5: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid |-> tx_en);

    assert_word_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !ser_ready) |=> (!tx_valid || $stable(tx_word)));

    assert_depth_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
        fill_count <= CNT_W'(DEPTH));

    assert_no_growth_enabled_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_en && $past(tx_en)) |-> (fill_count <= $past(fill_count)));

    assert_ready_drops_R8: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> !tx_ready_flag);

    assert_ready_rises_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_ready_flag) |-> ($past(ser_ready) && $past(fill_count) == '0));
endmodule

bind halfword_tx_queue halfword_tx_queue_chk #(
    .WORD_W (WORD_W),
    .DEPTH  (DEPTH),
    .CNT_W  (CNT_W)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .tx_en         (tx_en),
    .ser_ready     (ser_ready),
    .tx_valid      (tx_valid),
    .tx_word       (tx_word),
    .tx_ready_flag (tx_ready_flag),
    .commit        (commit),
    .fill_count    (fill_count)
);

// File: tb/sim_halfword_tx_queue.sv
module sim_halfword_tx_queue;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] host_data = '0;
    logic        ld_lo_n = 1'b1;
    logic        ld_hi_n = 1'b1;
    logic        tx_en = 1'b0;
    logic        ser_ready = 1'b0;
    logic [31:0] tx_word;
    logic        tx_valid;
    logic        tx_ready_flag;

    int checks = 0;
    int failures = 0;
    logic [31:0] exp_w [16];
    int exp_n = 0;

    always #10 clk = ~clk;

    halfword_tx_queue u0 (
        .clk(clk), .rst_n(rst_n), .host_data(host_data), .ld_lo_n(ld_lo_n),
        .ld_hi_n(ld_hi_n), .tx_en(tx_en), .ser_ready(ser_ready),
        .tx_word(tx_word), .tx_valid(tx_valid), .tx_ready_flag(tx_ready_flag)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic pulse_lo(input logic [15:0] d);
        @(negedge clk); host_data = d; ld_lo_n = 1'b0;
        repeat (3) @(negedge clk);
        ld_lo_n = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    task automatic pulse_hi(input logic [15:0] d);
        @(negedge clk); host_data = d; ld_hi_n = 1'b0;
        repeat (3) @(negedge clk);
        ld_hi_n = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    task automatic load_word(input logic [31:0] w);
        pulse_lo(w[15:0]);
        pulse_hi(w[31:16]);
    endtask

    // Drain with the serializer always ready and compare against exp_w
    task automatic drain_expect(input string req);
        int got = 0;
        @(negedge clk); tx_en = 1'b1; ser_ready = 1'b1; #1;
        for (int i = 0; i < 24; i++) begin
            if (tx_valid) begin
                if (got < exp_n) check(tx_word == exp_w[got], req, tx_word, exp_w[got]);
                got++;
            end
            @(negedge clk); #1;
        end
        check(got == exp_n, req, 32'(got), 32'(exp_n));
        check(tx_ready_flag == 1'b1, "R8", {31'd0, tx_ready_flag}, 32'd1);
        tx_en = 1'b0;
        exp_n = 0;
        @(negedge clk);
    endtask

    task automatic t_reset;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(tx_ready_flag == 1'b1, "R1", {31'd0, tx_ready_flag}, 32'd1);
        check(tx_valid == 1'b0, "R1", {31'd0, tx_valid}, 32'd0);
    endtask

    task automatic t_basic;
        load_word(32'hA1B2_C3D4);
        check(tx_ready_flag == 1'b0, "R8", {31'd0, tx_ready_flag}, 32'd0);
        load_word(32'h1234_5678);
        load_word(32'hDEAD_BEEF);
        check(tx_valid == 1'b0, "R5", {31'd0, tx_valid}, 32'd0);
        exp_w[0] = 32'hA1B2_C3D4; exp_w[1] = 32'h1234_5678; exp_w[2] = 32'hDEAD_BEEF;
        exp_n = 3;
        drain_expect("R6");
    endtask

    task automatic t_overfill;
        for (int i = 0; i < 9; i++) load_word(32'h0100_0000 * (i + 1) + 32'(i));
        for (int i = 0; i < 7; i++) exp_w[i] = 32'h0100_0000 * (i + 1) + 32'(i);
        exp_w[7] = 32'h0900_0008;
        exp_n = 8;
        drain_expect("R7");
    endtask

    task automatic t_orphan_hi;
        pulse_hi(16'hFFFF);
        check(tx_ready_flag == 1'b1, "R3", {31'd0, tx_ready_flag}, 32'd1);
        exp_n = 0;
        drain_expect("R3");
    endtask

    task automatic t_relo;
        pulse_lo(16'h1111);
        pulse_lo(16'h2222);
        pulse_hi(16'h3333);
        exp_w[0] = 32'h3333_2222; exp_n = 1;
        drain_expect("R2");
    endtask

    task automatic t_locked;
        @(negedge clk); tx_en = 1'b1; ser_ready = 1'b1;
        load_word(32'h5555_AAAA);
        check(tx_valid == 1'b0, "R4", {31'd0, tx_valid}, 32'd0);
        check(tx_ready_flag == 1'b1, "R4", {31'd0, tx_ready_flag}, 32'd1);
        @(negedge clk); tx_en = 1'b0;
        exp_n = 0;
        drain_expect("R4");
    endtask

    task automatic t_stall;
        load_word(32'hCAFE_0001);
        load_word(32'hCAFE_0002);
        @(negedge clk); ser_ready = 1'b0; tx_en = 1'b1; #1;
        check(tx_valid == 1'b1, "R5", {31'd0, tx_valid}, 32'd1);
        repeat (3) @(negedge clk);
        check(tx_word == 32'hCAFE_0001, "R6", tx_word, 32'hCAFE_0001);
        ser_ready = 1'b1;
        @(negedge clk);
        check(tx_word == 32'hCAFE_0002, "R6", tx_word, 32'hCAFE_0002);
        @(negedge clk);
        ser_ready = 1'b0;
        check(tx_valid == 1'b0, "R5", {31'd0, tx_valid}, 32'd0);
        repeat (2) @(negedge clk);
        check(tx_ready_flag == 1'b0, "R8", {31'd0, tx_ready_flag}, 32'd0);
        ser_ready = 1'b1;
        @(negedge clk);
        check(tx_ready_flag == 1'b1, "R8", {31'd0, tx_ready_flag}, 32'd1);
        tx_en = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        t_reset;
        t_basic;
        t_overfill;
        t_orphan_hi;
        t_relo;
        t_locked;
        t_stall;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule